// File: doc/BRIEF.md
# Dual-Compare Output Pulse Generator

This block drives one output pin from two compare values, a primary and a secondary, checked against one of two 16-bit time bases. Each time base is an up-counter with its own period register and run enable. When a count equals its period, the next count is zero. A match on the primary value raises the pin. A later match on the secondary value lowers it and sets a sticky interrupt flag.

A 3-bit mode field picks the behaviour. In the one-shot mode the channel makes exactly one pulse and then holds the pin low. Writing the control register again arms it for another pulse, so the channel never has to be switched off between pulses. In the repeating mode the channel makes one pulse in every timer period. Any other mode code turns the channel off and holds the pin low. All configuration goes through a simple write port. A separate input clears the flag.

Top module: `dual_compare_pulse`

## Requirements
- R1: After reset the pin and the flag are low, both counts are zero, both time bases are stopped, the mode is off, the compare values are zero and both periods are 0xFFFF.
- R2: A write with wrEn high stores wrData on the next edge. The addresses are: 0 primary compare, 1 secondary compare, 2 control, 3 run enables, 4 period of time base 0, 5 period of time base 1. In the control word, bits [2:0] hold the mode and bit 3 selects time base 0 (value 0) or time base 1 (value 1). In the run word, bit 0 enables time base 0 and bit 1 enables time base 1.
- R3: A time base whose run bit is set advances by one on each clock. When its count equals its period, it goes to 0x0000 on the next edge. A stopped time base holds its count.
- R4: Writing mode 3'b100 (one-shot) or 3'b101 (repeating) drives the pin low on the next edge and arms the channel, even if the pin was high. Any other mode code drives the pin low and keeps it low.
- R5: While the channel is armed, a primary match raises the pin on the next edge.
- R6: While the pin is high, a secondary match lowers the pin on the next edge and sets the flag on that same edge.
- R7: In one-shot mode the pin stays low after the falling edge and no further pulse occurs. Rewriting the control word re-arms the channel for one more pulse.
- R8: In repeating mode the channel re-arms after each falling edge, so one pulse occurs in every timer period.
- R9: The flag stays set until flagClr is high at an edge. If a set and a clear occur on the same edge, the set wins. A control write does not clear the flag.
- R10: Only the time base chosen by the select bit can cause matches. Counts on the other time base have no effect on the pin.
- R11: If the secondary value is above the period, the selected count never reaches it, so the pin stays high after it rises.
- R12: With equal primary and secondary values, the pin rises at the match and does not fall on the same count. It falls at the next match of that value, one period later, so no pulse lasts only one cycle.
- R13: A match counts only on an edge where the selected time base is running. A stopped count that sits on a compare value changes nothing. Once the time base runs, that value matches on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address for the write |
| wrData | input | 16 | Write data |
| flagClr | input | 1 | Clears the sticky interrupt flag |
| pulseOut | output | 1 | Output pin |
| flagOut | output | 1 | Sticky interrupt flag, set on each falling edge made by a secondary match |

## Verification
Every result is due exactly one edge after its cause, with no deeper pipeline:
- A register write takes effect at the first edge after wrEn is driven.
- A compare match is seen on the edge where the running count holds the value, and the pin and flag change at that same edge.
- A control write forces the pin low at its own edge.

The bench drives inputs at the falling clock edge. A behavioural model advances at every rising edge. Both pin and flag are compared with the model at each falling edge, so every one-edge latency is checked cycle-exactly. Directed checks after each scenario cover the counted pulses, the held-high case and the stopped-count case.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int NUM_TB = 2;
  localparam int SELW = (NUM_TB > 1) ? $clog2(NUM_TB) : 1;
  localparam int SEL_LSB = 3;

  localparam int A_PRI  = 0;
  localparam int A_SEC  = 1;
  localparam int A_CTRL = 2;
  localparam int A_RUN  = 3;
  localparam int A_PER0 = 4;

  localparam logic [2:0] MODE_OFF  = 3'b000;
  localparam logic [2:0] MODE_ONCE = 3'b100;
  localparam logic [2:0] MODE_RPT  = 3'b101;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_HIGH, ST_DONE} ocpState_t;

  // datapath -> control
  typedef struct packed {
    logic ctrlWrite;
    logic newPulseMode;
    logic repeatMode;
    logic hitPri;
    logic hitSec;
  } ocpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic pinRise;
    logic pinFall;
    logic flagSet;
  } ocpStrobe_t;
endpackage

// File: rtl/ocp_timebase.sv
module ocp_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic [TW-1:0] period,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (run) begin
      if (count == period) count <= '0;
      else                 count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ocp_datapath.sv
module ocp_datapath
  import ocp_pkg::*;
#(
  parameter int TW = 16,
  parameter int AW = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [AW-1:0]                wrAddr,
  input  logic [TW-1:0]                wrData,
  input  logic                         flagClr,
  input  ocpStrobe_t                   strobe,
  output ocpStatus_t                   status,
  output logic                         pulseOut,
  output logic                         flagOut,
  output logic [2:0]                   modeCode,
  output logic [NUM_TB-1:0]            runBits,
  output logic [NUM_TB-1:0][TW-1:0]    tbCount,
  output logic [NUM_TB-1:0][TW-1:0]    tbPeriod
);
  logic [TW-1:0]   priVal;
  logic [TW-1:0]   secVal;
  logic [SELW-1:0] selReg;
  logic            wrPri, wrSec, wrCtrl, wrRun;
  logic [TW-1:0]   selCount;
  logic            selRun;
  logic [2:0]      newMode;

  assign wrPri  = wrEn && (wrAddr == AW'(A_PRI));
  assign wrSec  = wrEn && (wrAddr == AW'(A_SEC));
  assign wrCtrl = wrEn && (wrAddr == AW'(A_CTRL));
  assign wrRun  = wrEn && (wrAddr == AW'(A_RUN));
  assign newMode = wrData[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priVal   <= '0;
      secVal   <= '0;
      modeCode <= MODE_OFF;
      selReg   <= '0;
      runBits  <= '0;
    end else begin
      if (wrPri) priVal <= wrData;
      if (wrSec) secVal <= wrData;
      if (wrCtrl) begin
        modeCode <= newMode;
        selReg   <= wrData[SEL_LSB +: SELW];
      end
      if (wrRun) runBits <= wrData[NUM_TB-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TB; i++) begin : g_tb
    always_ff @(posedge clk) begin
      if (!rstN)                                   tbPeriod[i] <= '1;
      else if (wrEn && (wrAddr == AW'(A_PER0 + i))) tbPeriod[i] <= wrData;
    end
    ocp_timebase #(.TW(TW)) u_tb (
      .clk    (clk),
      .rstN   (rstN),
      .run    (runBits[i]),
      .period (tbPeriod[i]),
      .count  (tbCount[i])
    );
  end

  assign selCount = tbCount[selReg];
  assign selRun   = runBits[selReg];

  always_comb begin
    status.ctrlWrite    = wrCtrl;
    status.newPulseMode = (newMode == MODE_ONCE) || (newMode == MODE_RPT);
    status.repeatMode   = (modeCode == MODE_RPT);
    status.hitPri       = selRun && (selCount == priVal);
    status.hitSec       = selRun && (selCount == secVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseOut <= 1'b0;
      flagOut  <= 1'b0;
    end else begin
      if (strobe.pinFall)      pulseOut <= 1'b0;
      else if (strobe.pinRise) pulseOut <= 1'b1;
      if (strobe.flagSet)      flagOut <= 1'b1;
      else if (flagClr)        flagOut <= 1'b0;
    end
  end
endmodule

// File: rtl/ocp_control.sv
module ocp_control
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ocpStatus_t status,
  output ocpStrobe_t strobe
);
  ocpState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (status.ctrlWrite) begin
      strobe.pinFall = 1'b1;
      stateNext = status.newPulseMode ? ST_ARMED : ST_IDLE;
    end else begin
      unique case (state)
        ST_ARMED: if (status.hitPri) begin
          strobe.pinRise = 1'b1;
          stateNext = ST_HIGH;
        end
        ST_HIGH: if (status.hitSec) begin
          strobe.pinFall = 1'b1;
          strobe.flagSet = 1'b1;
          stateNext = status.repeatMode ? ST_ARMED : ST_DONE;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/dual_compare_pulse.sv
module dual_compare_pulse
  import ocp_pkg::*;
#(
  parameter int TW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [TW-1:0] wrData,
  input  logic          flagClr,
  output logic          pulseOut,
  output logic          flagOut
);
  ocpStatus_t                status;
  ocpStrobe_t                strobe;
  logic [2:0]                modeCode;
  logic [NUM_TB-1:0]         runBits;
  logic [NUM_TB-1:0][TW-1:0] tbCount;
  logic [NUM_TB-1:0][TW-1:0] tbPeriod;

  ocp_datapath #(.TW(TW), .AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .flagClr  (flagClr),
    .strobe   (strobe),
    .status   (status),
    .pulseOut (pulseOut),
    .flagOut  (flagOut),
    .modeCode (modeCode),
    .runBits  (runBits),
    .tbCount  (tbCount),
    .tbPeriod (tbPeriod)
  );

  ocp_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );
endmodule

// File: rtl/ocp_checker.sv
module ocp_checker
  import ocp_pkg::*;
#(
  parameter int TW = 16,
  parameter int AW = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [AW-1:0]             wrAddr,
  input logic                      flagClr,
  input logic                      pulseOut,
  input logic                      flagOut,
  input logic [2:0]                modeCode,
  input logic [NUM_TB-1:0]         runBits,
  input logic [NUM_TB-1:0][TW-1:0] tbCount,
  input logic [NUM_TB-1:0][TW-1:0] tbPeriod
);
  logic ctlWr;
  assign ctlWr = wrEn && (wrAddr == AW'(A_CTRL));

  AST_CTRL_WRITE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> !pulseOut); // R4
  AST_OFF_MODE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !((modeCode == MODE_ONCE) || (modeCode == MODE_RPT)) |-> !pulseOut); // R4
  AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pulseOut) && !$past(ctlWr)) |-> flagOut); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut && !flagClr) |=> flagOut); // R9

  for (genvar i = 0; i < NUM_TB; i++) begin : g_chk
    AST_TB_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      (runBits[i] && tbCount[i] == tbPeriod[i]) |=> (tbCount[i] == '0)); // R3
    AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !runBits[i] |=> $stable(tbCount[i])); // R3
    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (runBits[i] && tbCount[i] != tbPeriod[i]) |=> (tbCount[i] == $past(tbCount[i]) + 1'b1)); // R3
  end
endmodule

bind dual_compare_pulse ocp_checker #(.TW(TW), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .flagClr  (flagClr),
  .pulseOut (pulseOut),
  .flagOut  (flagOut),
  .modeCode (modeCode),
  .runBits  (runBits),
  .tbCount  (tbCount),
  .tbPeriod (tbPeriod)
);

// File: tb/dual_compare_pulse_test.sv
`timescale 1ns/1ps
module dual_compare_pulse_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic flagClr = 1'b0;
  logic pulseOut, flagOut;

  always #2 clk = ~clk;

  dual_compare_pulse uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .flagClr(flagClr), .pulseOut(pulseOut), .flagOut(flagOut)
  );

  int vectors = 0;
  int misses = 0;
  string curReq = "R1";

  // behavioural reference
  int mPri, mSec, mMode, mSel, mState, mPin, mFlag, mRise;
  int mRun[2];
  int mPer[2];
  int mCnt[2];

  always @(posedge clk) begin
    if (!rstN) begin
      mPri = 0; mSec = 0; mMode = 0; mSel = 0; mState = 0; mPin = 0; mFlag = 0;
      for (int i = 0; i < 2; i++) begin mRun[i] = 0; mPer[i] = 65535; mCnt[i] = 0; end
    end else begin
      bit hp, hs, cw, setF;
      hp = (mRun[mSel] != 0) && (mCnt[mSel] == mPri);
      hs = (mRun[mSel] != 0) && (mCnt[mSel] == mSec);
      cw = wrEn && (wrAddr == 3'd2);
      setF = 0;
      if (cw) begin
        mPin = 0;
        mState = (wrData[2:0] == 3'b100 || wrData[2:0] == 3'b101) ? 1 : 0;
      end else if (mState == 1 && hp) begin
        mPin = 1; mState = 2; mRise++;
      end else if (mState == 2 && hs) begin
        mPin = 0; setF = 1; mFlag = 1;
        mState = (mMode == 5) ? 1 : 3;
      end
      if (!setF && flagClr) mFlag = 0;
      for (int i = 0; i < 2; i++)
        if (mRun[i] != 0) mCnt[i] = (mCnt[i] == mPer[i]) ? 0 : ((mCnt[i] + 1) & 16'hFFFF);
      if (wrEn) begin
        case (wrAddr)
          3'd0: mPri = wrData;
          3'd1: mSec = wrData;
          3'd2: begin mMode = wrData[2:0]; mSel = wrData[3]; end
          3'd3: begin mRun[0] = wrData[0]; mRun[1] = wrData[1]; end
          3'd4: mPer[0] = wrData;
          3'd5: mPer[1] = wrData;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and DUT pulse monitor
  int dRise = 0;
  int glitches = 0;
  int hiLen = 0;
  logic prevPulse = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      if (pulseOut !== mPin[0] || flagOut !== mFlag[0]) begin
        misses++;
        $display("FAIL %s cycle compare: pin=%0b flag=%0b expected pin=%0d flag=%0d",
                 curReq, pulseOut, flagOut, mPin, mFlag);
      end
      if (pulseOut && !prevPulse) begin dRise++; hiLen = 1; end
      else if (pulseOut) hiLen++;
      if (!pulseOut && prevPulse && hiLen < 2) glitches++;
      prevPulse = pulseOut;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a[2:0]; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(4 * 150000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int base, mbase, g0, p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    chk("R1 pin after reset", pulseOut, 0);
    chk("R1 flag after reset", flagOut, 0);

    // one-shot on time base 0
    curReq = "R2/R3/R5/R6/R7";
    wr(0, 3); wr(1, 7); wr(4, 10);
    wr(2, 4); wr(3, 1);
    base = dRise;
    idle(40);
    chk("R7 single pulse count", dRise - base, 1);
    chk("R6 flag after falling edge", flagOut, 1);
    chk("R7 pin stays low", pulseOut, 0);

    curReq = "R9";
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    chk("R9 flag cleared", flagOut, 0);
    wr(2, 4);
    chk("R9 flag not cleared by control write", flagOut, 0);

    curReq = "R7";
    base = dRise;
    idle(25);
    chk("R7 re-armed pulse", dRise - base, 1);

    // repeating mode
    curReq = "R8/R9";
    wr(2, 5);
    base = dRise; mbase = mRise;
    idle(50);
    chk("R8 pulses per period", dRise - base, mRise - mbase);
    chk("R8 several pulses", (dRise - base) >= 4, 1);
    @(negedge clk); flagClr = 1'b1;
    idle(30);
    @(negedge clk); flagClr = 1'b0;
    idle(12);

    // select time base 1
    curReq = "R10";
    wr(3, 0); wr(5, 5); wr(0, 2); wr(1, 4);
    wr(2, 13); wr(3, 1);
    base = dRise;
    idle(20);
    chk("R10 unselected base ignored", dRise - base, 0);
    wr(3, 2);
    base = dRise; mbase = mRise;
    idle(24);
    chk("R10 selected base pulses", dRise - base, mRise - mbase);
    chk("R10 selected base active", (dRise - base) >= 3, 1);

    // secondary above period
    curReq = "R11";
    wr(3, 0); wr(2, 0); wr(4, 10); wr(0, 2); wr(1, 20);
    wr(2, 5); wr(3, 1);
    base = dRise;
    idle(15);
    chk("R11 pin high", pulseOut, 1);
    idle(35);
    chk("R11 pin still high", pulseOut, 1);
    chk("R11 single rise", dRise - base, 1);

    // equal compare values
    curReq = "R12";
    wr(0, 4); wr(1, 4); wr(2, 5);
    g0 = glitches;
    base = dRise; mbase = mRise;
    idle(60);
    chk("R12 no one-cycle pulse", glitches - g0, 0);
    chk("R12 rises", dRise - base, mRise - mbase);

    // stopped count sitting on the compare value
    curReq = "R13";
    wr(3, 0);
    p = mCnt[0];
    wr(0, p); wr(1, p); wr(2, 4);
    idle(10);
    chk("R13 stopped count no match", pulseOut, 0);
    wr(3, 1);
    idle(1);
    chk("R13 first running edge matches", pulseOut, 1);

    curReq = "R4";
    wr(2, 4);
    chk("R4 arm write drives low", pulseOut, 0);
    wr(2, 3);
    base = dRise;
    idle(30);
    chk("R4 unused code stays low", dRise - base, 0);
    wr(2, 0);
    idle(30);
    chk("R4 off mode stays low", dRise - base, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule